// File: doc/BRIEF.md
# Predicated Execute Unit with Status Flags

This block is the integer execute stage of a small processor core. It holds four status flags (negative, zero, carry, overflow) in a register and accepts one operation per cycle. Each operation names a predicate code, an opcode, a flag-write request bit, two 32-bit operands and an immediate shift applied to the second operand. The predicate is checked against the flags held at that moment. If the predicate fails, the operation is dropped and leaves no trace. If it holds, the unit computes the result, registers it for writeback when the opcode produces one, and updates the flags when asked to.

The arithmetic operations are add, add-with-carry and subtract. The logical operations are AND and XOR. Four test operations (compare, compare-negated, bit test and equality test) only ever update the flags. Logical operations take their carry from the last bit the operand shifter pushed out. This lets a test-and-branch sequence inspect a single bit without a separate shift step. Results leave through a registered valid/ready port. An operation accepted in one cycle sees the flags written by the operation accepted in the cycle before it.

Top module: `pex_unit`

## Requirements
- R1: The 4-bit `op_cond` predicate passes as follows. 0: Z. 1: !Z. 2: C. 3: !C. 4: N. 5: !N. 6: V. 7: !V. 8: C && !Z. 9: !C or Z. 10: N==V. 11: N!=V. 12: !Z && N==V. 13: Z or N!=V. 14: always. 15: never. `flags` is {N,Z,C,V}, with N at bit 3 and V at bit 0.
- R2: An accepted operation whose predicate fails produces a result beat with `res_wr`=0. It leaves `res_data` and `flags` unchanged. Code 15 always behaves this way.
- R3: Opcodes are 0 ADD (a+b'), 1 ADC (a+b'+C), 2 SUB (a-b'), 3 AND, 4 XOR, where b' is the shifted second operand. When the predicate passes they present the result on `res_data` with `res_wr`=1 one cycle after acceptance. They change `flags` only when `op_setf`=1.
- R4: For arithmetic flag updates, N is result bit 31 and Z means the result is zero. For subtraction, C is the carry out of a+~b'+1, so C=1 exactly when unsigned a>=b'. For addition, C is the carry out. V is set when the signed result overflows.
- R5: Test opcodes 5 CMP (a-b'), 6 CMN (a+b'), 7 TST (a AND b') and 8 TEQ (a XOR b') always update flags when their predicate passes and never set `res_wr`. CMP of 0x7FFFFFFF with 0xFFFFFFFF gives flags 4'b1001. CMN of 0x7FFFFFFF with 0xFFFFFFFF shifted left by 2 gives 4'b0010.
- R6: The second operand is shifted logically by `op_shamt` (0 to 31). The shift goes left when `op_shdir`=0 and right when `op_shdir`=1, with zeros filled in.
- R7: A logical flag update (AND, XOR, TST, TEQ) sets N and Z from the result and sets C to the last bit shifted out. C is kept when the shift amount is 0, and V is always kept. TST of 0x7FFFFFFF with 0xFFFFFFFF shifted right by 1 sets C=1.
- R8: ADC uses the stored C as carry-in. ADD with `op_setf`=1 on the low halves, followed at once by ADC on the high halves, yields a correct 64-bit sum.
- R9: `op_ready` is high when no result is held or `res_ready` is high. While `res_valid`=1 and `res_ready`=0, all outputs hold. An operation accepted in the next cycle sees flags written by the previous one.
- R10: A synchronous active-low reset clears `flags`, `res_valid`, `res_wr` and `res_data` to 0.
- R11: Opcodes 9 to 15 are accepted but change neither `res_data` nor `flags`, and they give `res_wr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Unit can take an operation |
| op_cond | input | 4 | Predicate code |
| op_code | input | 4 | Opcode |
| op_setf | input | 1 | Request flag update (non-test ops) |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand, before shifting |
| op_shdir | input | 1 | Shift direction, 0 left, 1 right |
| op_shamt | input | $clog2(WIDTH) | Shift amount |
| res_valid | output | 1 | Result beat present |
| res_ready | input | 1 | Consumer takes the beat |
| res_wr | output | 1 | Beat carries a value to write back |
| res_data | output | WIDTH | Last written result |
| flags | output | 4 | {N,Z,C,V} |

## Verification
The bench builds the unit with the default WIDTH of 32. At that width the exact boundary values from the requirements can be applied: signed overflow at 0x7FFFFFFF, wrap at 0xFFFFFFFF, and every shift amount from 0 to 31, including the carry taken from bit 0 or bit 31. Six flag patterns are prepared through compare operations, and all sixteen predicates are tried against each one. A randomized stream with back-pressure then exercises back-to-back flag dependencies.

// File: rtl/pex_pkg.sv
// Shared opcode and flag definitions for the predicated execute unit.
// Assumes a 4-bit opcode field; values above OP_TEQ are undefined.
package pex_pkg;
    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_AND = 4'd3,
        OP_XOR = 4'd4,
        OP_CMP = 4'd5,
        OP_CMN = 4'd6,
        OP_TST = 4'd7,
        OP_TEQ = 4'd8
    } pex_op_e;

    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;
endpackage

// File: rtl/pex_cond_eval.sv
// Predicate evaluator: decides from the stored flags whether an operation runs.
// Assumes flags ordered {N,Z,C,V}; code 15 never passes.
module pex_cond_eval
    import pex_pkg::*;
(
    input  logic [3:0] flags_i,
    input  logic [3:0] cond_i,
    output logic       pass_o
);
    logic n, z, c, v;
    assign n = flags_i[FLG_N];
    assign z = flags_i[FLG_Z];
    assign c = flags_i[FLG_C];
    assign v = flags_i[FLG_V];

    // Decode the predicate: pairs of codes are complements except 14/15.
    always_comb begin
        logic base;
        unique case (cond_i[3:1])
            3'd0: base = z;
            3'd1: base = c;
            3'd2: base = n;
            3'd3: base = v;
            3'd4: base = c & ~z;
            3'd5: base = (n == v);
            3'd6: base = ~z & (n == v);
            default: base = 1'b1;
        endcase
        if (cond_i == 4'hF) pass_o = 1'b0;
        else                pass_o = cond_i[0] ? ~base : base;
    end
endmodule

// File: rtl/pex_shifter.sv
// Immediate logical shifter for the second operand, with shifter carry-out.
// Assumes amount 0 passes the operand through and returns the incoming carry.
module pex_shifter #(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] b_i,
    input  logic             dir_i,
    input  logic [SHW-1:0]   amt_i,
    input  logic             c_i,
    output logic [WIDTH-1:0] b_o,
    output logic             c_o
);
    logic [2*WIDTH-1:0] ext;

    // Shift inside a double-width window so the last bit out lands at a fixed slot.
    always_comb begin
        ext = '0;
        b_o = b_i;
        c_o = c_i;
        if (amt_i != '0) begin
            if (!dir_i) begin
                ext = {{WIDTH{1'b0}}, b_i} << amt_i;
                b_o = ext[WIDTH-1:0];
                c_o = ext[WIDTH];
            end else begin
                ext = {b_i, {WIDTH{1'b0}}} >> amt_i;
                b_o = ext[2*WIDTH-1:WIDTH];
                c_o = ext[WIDTH-1];
            end
        end
    end
endmodule

// File: rtl/pex_alu.sv
// Combinational datapath: one shared adder for all arithmetic and compare ops,
// plus AND/XOR. Produces candidate flags; the caller decides whether to store them.
// Assumes b_i is already shifted and shc_i is the shifter carry.
module pex_alu
    import pex_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [3:0]       op_i,
    input  logic [3:0]       flags_i,
    input  logic             shc_i,
    output logic [WIDTH-1:0] res_o,
    output logic [3:0]       flg_o,
    output logic             wr_o,
    output logic             test_o,
    output logic             known_o,
    output logic             logic_o
);
    logic             sub, arith;
    logic [WIDTH-1:0] bx;
    logic             cin;
    logic [WIDTH:0]   sum;
    logic             ovf;
    pex_op_e          op;

    assign op = pex_op_e'(op_i);

    // Shared adder: subtraction is a + ~b + 1, ADC injects the stored carry.
    always_comb begin
        sub = (op == OP_SUB) || (op == OP_CMP);
        bx  = sub ? ~b_i : b_i;
        cin = sub | ((op == OP_ADC) & flags_i[FLG_C]);
        sum = {1'b0, a_i} + {1'b0, bx} + {{WIDTH{1'b0}}, cin};
        ovf = (a_i[WIDTH-1] == bx[WIDTH-1]) && (sum[WIDTH-1] != a_i[WIDTH-1]);
    end

    // Select result and classify the opcode.
    always_comb begin
        res_o   = '0;
        arith   = 1'b0;
        logic_o = 1'b0;
        wr_o    = 1'b0;
        test_o  = 1'b0;
        known_o = 1'b1;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB: begin res_o = sum[WIDTH-1:0]; arith = 1'b1; wr_o = 1'b1; end
            OP_CMP, OP_CMN:         begin res_o = sum[WIDTH-1:0]; arith = 1'b1; test_o = 1'b1; end
            OP_AND:                 begin res_o = a_i & b_i; logic_o = 1'b1; wr_o = 1'b1; end
            OP_XOR:                 begin res_o = a_i ^ b_i; logic_o = 1'b1; wr_o = 1'b1; end
            OP_TST:                 begin res_o = a_i & b_i; logic_o = 1'b1; test_o = 1'b1; end
            OP_TEQ:                 begin res_o = a_i ^ b_i; logic_o = 1'b1; test_o = 1'b1; end
            default:                known_o = 1'b0;
        endcase
    end

    // Candidate flags: arithmetic uses adder carry/overflow, logical keeps V.
    always_comb begin
        flg_o = flags_i;
        if (arith || logic_o) begin
            flg_o[FLG_N] = res_o[WIDTH-1];
            flg_o[FLG_Z] = (res_o == '0);
            flg_o[FLG_C] = arith ? sum[WIDTH] : shc_i;
            flg_o[FLG_V] = arith ? ovf : flags_i[FLG_V];
        end
    end
endmodule

// File: rtl/pex_unit.sv
// Predicated execute unit: flag register, predicate check, shifter, datapath and
// a registered valid/ready result port. One operation per cycle.
// Assumes synchronous active-low reset; the result register holds its last
// written value when a beat does not write back.
module pex_unit
    import pex_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    output logic             op_ready,
    input  logic [3:0]       op_cond,
    input  logic [3:0]       op_code,
    input  logic             op_setf,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             op_shdir,
    input  logic [SHW-1:0]   op_shamt,
    output logic             res_valid,
    input  logic             res_ready,
    output logic             res_wr,
    output logic [WIDTH-1:0] res_data,
    output logic [3:0]       flags
);
    logic [3:0]       flags_q;
    logic             pass;
    logic [WIDTH-1:0] b_sh;
    logic             sh_c;
    logic [WIDTH-1:0] alu_res;
    logic [3:0]       alu_flg;
    logic             alu_wr, alu_test, alu_known, alu_logic;
    logic             accept, exec;

    pex_cond_eval u_cond (
        .flags_i (flags_q),
        .cond_i  (op_cond),
        .pass_o  (pass)
    );

    pex_shifter #(.WIDTH(WIDTH)) u_shift (
        .b_i   (op_b),
        .dir_i (op_shdir),
        .amt_i (op_shamt),
        .c_i   (flags_q[FLG_C]),
        .b_o   (b_sh),
        .c_o   (sh_c)
    );

    pex_alu #(.WIDTH(WIDTH)) u_alu (
        .a_i     (op_a),
        .b_i     (b_sh),
        .op_i    (op_code),
        .flags_i (flags_q),
        .shc_i   (sh_c),
        .res_o   (alu_res),
        .flg_o   (alu_flg),
        .wr_o    (alu_wr),
        .test_o  (alu_test),
        .known_o (alu_known),
        .logic_o (alu_logic)
    );

    // Accept whenever the output slot is empty or being drained.
    assign op_ready = !res_valid || res_ready;
    assign accept   = op_valid && op_ready;
    assign exec     = accept && pass && alu_known;

    // Result port register: advances only when the slot may change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_wr    <= 1'b0;
            res_data  <= '0;
        end else if (op_ready) begin
            res_valid <= op_valid;
            res_wr    <= exec && alu_wr;
            if (exec && alu_wr) res_data <= alu_res;
        end
    end

    // Flag register: written by tests always, by other ops only on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                              flags_q <= 4'b0000;
        else if (exec && (alu_test || op_setf)) flags_q <= alu_flg;
    end

    assign flags = flags_q;

    // A failing predicate leaves flags and result untouched.
    assert_fail_no_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !pass |=> !res_wr && flags == $past(flags) && res_data == $past(res_data));

    // Code 15 never writes back.
    assert_never_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_cond == 4'hF |=> !res_wr);

    // Test operations never produce a writeback.
    assert_test_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_code >= 4'd5 |=> !res_wr);

    // Logical operations keep V.
    assert_logic_keeps_v_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept && alu_logic |=> flags[FLG_V] == $past(flags[FLG_V]));

    // Non-test ops without the request bit keep the flags.
    assert_no_setf_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept && op_code <= 4'd4 && !op_setf |=> $stable(flags));

    // Stalled beat holds every output.
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_wr) && $stable(flags));

    // Reset clears the visible state.
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> flags == 4'b0000 && !res_valid && res_data == '0);
endmodule

// File: tb/test_pex_unit.sv
`timescale 1ns/1ps
module test_pex_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        op_valid, op_ready, op_setf, op_shdir, res_valid, res_ready, res_wr;
    logic [3:0]  op_cond, op_code, flags;
    logic [31:0] op_a, op_b, res_data;
    logic [4:0]  op_shamt;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    bit          m_valid, m_wr;
    logic [31:0] m_data;
    logic [3:0]  m_flags;

    always #2.5 clk = ~clk;

    pex_unit #(.WIDTH(32)) i_pex_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
        .op_cond(op_cond), .op_code(op_code), .op_setf(op_setf), .op_a(op_a),
        .op_b(op_b), .op_shdir(op_shdir), .op_shamt(op_shamt),
        .res_valid(res_valid), .res_ready(res_ready), .res_wr(res_wr),
        .res_data(res_data), .flags(flags)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic bit pred(input logic [3:0] code, input logic [3:0] f);
        bit n = f[3], z = f[2], c = f[1], v = f[0];
        case (code)
            4'd0:  return z == 1;
            4'd1:  return z == 0;
            4'd2:  return c == 1;
            4'd3:  return c == 0;
            4'd4:  return n == 1;
            4'd5:  return n == 0;
            4'd6:  return v == 1;
            4'd7:  return v == 0;
            4'd8:  return c && !z;
            4'd9:  return !c || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1;
            default: return 0;
        endcase
    endfunction

    // Apply one operation for one clock and compare everything afterwards.
    task automatic step(input string tag, input bit v, input logic [3:0] cnd, input logic [3:0] code,
                        input bit s, input logic [31:0] a, input logic [31:0] b,
                        input bit dir, input int amt, input bit rr);
        bit          rdy;
        logic [31:0] sb, res;
        bit          sc, c, vv, isarith, islog, writes, istest;
        longint      ua, ub, u, sa, sbs, ss;
        op_valid = v; op_cond = cnd; op_code = code; op_setf = s; op_a = a; op_b = b;
        op_shdir = dir; op_shamt = amt[4:0]; res_ready = rr;
        #1;
        rdy = !m_valid || rr;
        check("R9", "op_ready", {31'b0, op_ready}, {31'b0, rdy});
        // shift one bit at a time, remembering the last bit out
        sb = b; sc = m_flags[1];
        for (int i = 0; i < amt; i++) begin
            if (!dir) begin sc = sb[31]; sb = sb << 1; end
            else      begin sc = sb[0];  sb = sb >> 1; end
        end
        ua = longint'(a); ub = longint'(sb);
        sa = longint'($signed(a)); sbs = longint'($signed(sb));
        isarith = (code <= 2) || code == 5 || code == 6;
        islog   = code == 3 || code == 4 || code == 7 || code == 8;
        writes  = code <= 4;
        istest  = code >= 5 && code <= 8;
        res = 0; c = 0; vv = 0;
        if (code == 2 || code == 5) begin
            res = a - sb; c = ua >= ub; ss = sa - sbs;
            vv = ss > 64'sd2147483647 || ss < -64'sd2147483648;
        end else if (isarith) begin
            u = ua + ub + ((code == 1) ? longint'(m_flags[1]) : 0);
            res = u[31:0]; c = u > 64'hFFFF_FFFF;
            ss = sa + sbs + ((code == 1) ? longint'(m_flags[1]) : 0);
            vv = ss > 64'sd2147483647 || ss < -64'sd2147483648;
        end else if (code == 3 || code == 7) res = a & sb;
        else if (code == 4 || code == 8) res = a ^ sb;
        if (rdy) begin
            m_valid = v;
            m_wr = 0;
            if (v && pred(cnd, m_flags) && (isarith || islog)) begin
                if (writes) begin m_wr = 1; m_data = res; end
                if (istest || s) begin
                    if (isarith) m_flags = {res[31], res == 0, c, vv};
                    else         m_flags = {res[31], res == 0, sc, m_flags[0]};
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "res_valid", {31'b0, res_valid}, {31'b0, m_valid});
        check(tag, "res_wr", {31'b0, res_wr}, {31'b0, m_wr});
        check(tag, "res_data", res_data, m_data);
        check(tag, "flags", {28'b0, flags}, {28'b0, m_flags});
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL R9 watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] setup_a [6] = '{32'd1, 32'd5, 32'd1, 32'h8000_0000, 32'd2, 32'h7FFF_FFFF};
        logic [31:0] setup_b [6] = '{32'd1, 32'd5, 32'd2, 32'd1, 32'd1, 32'hFFFF_FFFF};
        logic [3:0]  setup_o [6] = '{4'd6, 4'd5, 4'd5, 4'd5, 4'd5, 4'd5};
        logic [31:0] lo_word;
        rst_n = 0; op_valid = 0; op_cond = 0; op_code = 0; op_setf = 0; op_a = 0; op_b = 0;
        op_shdir = 0; op_shamt = 0; res_ready = 1;
        m_valid = 0; m_wr = 0; m_data = 0; m_flags = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        check("R10", "flags", {28'b0, flags}, 32'd0);
        check("R10", "res_valid", {31'b0, res_valid}, 32'd0);
        check("R10", "res_data", res_data, 32'd0);
        check("R10", "res_wr", {31'b0, res_wr}, 32'd0);
        rst_n = 1;

        // R5 exact compare cases
        step("R5", 1, 4'hE, 4'd5, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 0, 1);
        check("R5", "cmp flags", {28'b0, flags}, 32'b1001);
        step("R5", 1, 4'hE, 4'd6, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 0, 2, 1);
        check("R5", "cmn flags", {28'b0, flags}, 32'b0010);
        // R7 bit test with shifter carry, then equality test
        step("R7", 1, 4'hE, 4'd7, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 1, 1);
        check("R7", "tst flags", {28'b0, flags}, 32'b0010);
        step("R7", 1, 4'hE, 4'd8, 0, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 1, 1);
        check("R7", "teq flags", {28'b0, flags}, 32'b0110);
        // R7 zero shift keeps C, V held across logical ops
        step("R5", 1, 4'hE, 4'd5, 0, 32'h8000_0000, 32'd1, 0, 0, 1);
        step("R7", 1, 4'hE, 4'd3, 1, 32'h0000_00F0, 32'h0000_000F, 0, 0, 1);
        check("R7", "and zero-shift flags", {28'b0, flags}, 32'b0111);
        step("R6", 1, 4'hE, 4'd4, 1, 32'h0, 32'h8000_0001, 0, 31, 1);
        step("R6", 1, 4'hE, 4'd4, 1, 32'h0, 32'h8000_0001, 1, 31, 1);

        // R1 every predicate against six flag patterns
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 16; k++) begin
                step("R5", 1, 4'hE, setup_o[p], 0, setup_a[p], setup_b[p], 0, 0, 1);
                step((k == 15) ? "R2" : "R1", 1, k[3:0], 4'd0, 0, 32'd100 + k, 32'd7 * p, 0, 0, 1);
            end
        end

        // R8 64-bit add across two halves
        step("R8", 1, 4'hE, 4'd0, 1, 32'hFFFF_FFFF, 32'd1, 0, 0, 1);
        lo_word = res_data;
        step("R8", 1, 4'hE, 4'd1, 0, 32'd5, 32'd7, 0, 0, 1);
        check("R8", "sum low", lo_word, 32'd0);
        check("R8", "sum high", res_data, 32'd13);

        // R3 writes without flag request leave flags
        step("R3", 1, 4'hE, 4'd2, 0, 32'd3, 32'd9, 0, 0, 1);
        step("R4", 1, 4'hE, 4'd2, 1, 32'd3, 32'd9, 0, 0, 1);
        step("R4", 1, 4'hE, 4'd0, 1, 32'h7FFF_FFFF, 32'd1, 0, 0, 1);
        // R11 undefined opcodes ignored
        step("R11", 1, 4'hE, 4'd12, 1, 32'd1, 32'd1, 0, 0, 1);
        step("R11", 1, 4'hE, 4'd15, 1, 32'd0, 32'd0, 0, 0, 1);

        // R9 stall: result held while consumer is not ready
        step("R9", 1, 4'hE, 4'd0, 1, 32'd10, 32'd20, 0, 0, 0);
        step("R9", 1, 4'hE, 4'd0, 1, 32'd11, 32'd22, 0, 0, 0);
        step("R9", 1, 4'hE, 4'd0, 1, 32'd12, 32'd24, 0, 0, 0);
        step("R9", 0, 4'hE, 4'd0, 0, 32'd0, 32'd0, 0, 0, 1);
        step("R9", 0, 4'hE, 4'd0, 0, 32'd0, 32'd0, 0, 0, 1);

        // R3 randomized stream with back-pressure and flag dependencies
        for (int i = 0; i < 500; i++) begin
            logic [3:0] rc;
            rc = ($urandom % 3 == 0) ? 4'($urandom) : 4'hE;
            step("R3", ($urandom % 5) != 0, rc, 4'($urandom % 10), 1'($urandom),
                 $urandom, $urandom, 1'($urandom), int'($urandom % 32), ($urandom % 4) != 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule